// File: doc/BRIEF.md
# Multi-queue round-robin output arbiter

This block is the arbitration stage in front of one output of a mesh router. Every source direction that may send to this output gets its own small queue. A round-robin picker then chooses one of the queues that hold data and presents the head of that queue on the single output handshake. Because each source has its own queue, a source whose traffic is stalled cannot hold up traffic that is waiting in another source's queue.

Each source writes through a valid/ready pair. A queue that is full drops its ready, so no word is lost. The output raises valid whenever any queue holds data. A word leaves its queue only in a cycle where the output is both valid and ready. After a transfer, the top priority moves to the source just after the one that was served. While the output is stalled, the choice of source is frozen. The number of sources, the queue depth and the payload width are parameters, with defaults of 4, 4 and 32.

Top module: `rr_queue_mux`

## Requirements
- R1: During reset and in the cycle after it, `dst_valid` is low and every `src_ready` bit is high. The priority pointer starts at source 0, so when all sources write in the same cycle, source 0 is served first.
- R2: Words from one source leave in the same order in which that source's writes were accepted. No word is duplicated or dropped.
- R3: `src_ready[s]` is low exactly when queue s holds DEPTH words. This holds even in a cycle where that queue is being popped. A write offered while ready is low has no effect.
- R4: `dst_valid` is high exactly when at least one queue holds a word. A word accepted at one clock edge is visible at the output after that edge.
- R5: When no grant is being held, the served queue is the first non-empty queue found by scanning from the priority pointer upward, wrapping from source NUM_SRC-1 back to source 0. Empty queues are skipped.
- R6: After a cycle where `dst_valid` and `dst_ready` are both high, the pointer moves to the served source plus one, modulo NUM_SRC. In any other cycle the pointer keeps its value.
- R7: While `dst_valid` is high and `dst_ready` is low, `dst_data` and the served source stay unchanged in the next cycle. This holds even if a queue with higher priority becomes non-empty.
- R8: A queue that is not full accepts a write and gives up its head in the same cycle. Its occupancy then stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | NUM_SRC | Write request, one bit per source |
| src_ready | output | NUM_SRC | Queue has room, one bit per source |
| src_data | input | NUM_SRC*DATA_W | Payloads; source s uses bits [s*DATA_W +: DATA_W] |
| dst_valid | output | 1 | Some queue holds a word |
| dst_ready | input | 1 | Downstream accepts the word this cycle |
| dst_data | output | DATA_W | Head word of the served queue |

## Verification
The assertions assume that `dst_ready` and `src_valid` are driven to known values in every cycle once reset is released. They also assume that a payload offered on a source stays in its slice while that source's valid is high. The stimulus satisfies both assumptions. It changes inputs only on the falling clock edge. It keeps every bit defined. Each source's payload is its own index followed by a running sequence number, so order loss or cross-source mixing shows up as a wrong word. Traffic runs through directed phases: simultaneous first writes, full back-pressure, release, and sparse sources. A long random phase follows, in which both the write density and the downstream readiness change.

// File: rtl/rqm_pkg.sv
package rqm_pkg;

   // Index width for a count of n items (at least one bit).
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // True when n is a power of two greater than one.
   function automatic bit is_pow2(input int unsigned n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rqm_fifo.sv
module rqm_fifo #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_avail
);
   import rqm_pkg::*;

   localparam int unsigned AW = idx_w(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit          P2 = is_pow2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0]     cnt_q;
   logic              push, pop;

   // A full queue refuses writes, even when it is popped in the same cycle.
   assign wr_ready = (cnt_q != CW'(DEPTH));
   assign rd_avail = (cnt_q != '0);
   assign push     = wr_valid & wr_ready;
   assign pop      = rd_pop & rd_avail;
   assign rd_data  = mem[rp_q];

   generate
      if (P2) begin : g_wrap_free
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_nx;
         if (pop)  rp_q <= rp_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R3: a full queue that is popped loses exactly one word and takes none.
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ready && rd_pop) |=> (cnt_q == CW'(DEPTH - 1)));

   // R2: the arbiter never pops a queue that is empty.
   a_r2_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> rd_avail);

   // R8: a write and a pop in the same cycle leave the occupancy unchanged.
   a_r8_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && rd_pop) |=> $stable(cnt_q));

endmodule

// File: rtl/rqm_rr_pick.sv
module rqm_rr_pick #(
   parameter int unsigned NUM_SRC = 4,
   localparam int unsigned IW     = rqm_pkg::idx_w(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic               take,
   input  logic               stall,
   output logic [IW-1:0]      grant,
   output logic               any
);
   logic [IW-1:0] ptr_q, pick, hold_idx_q;
   logic          hold_q;

   assign any = |req;

   // Scan from the pointer upward, wrapping, and take the first non-empty queue.
   always_comb begin
      logic found;
      found = 1'b0;
      pick  = ptr_q;
      for (int k = 0; k < int'(NUM_SRC); k++) begin
         int unsigned pos;
         pos = int'(ptr_q) + k;
         if (pos >= NUM_SRC) pos = pos - NUM_SRC;
         if (!found && req[pos]) begin
            found = 1'b1;
            pick  = IW'(pos);
         end
      end
   end

   // A stalled output keeps the source it was serving.
   assign grant = hold_q ? hold_idx_q : pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         hold_q     <= 1'b0;
         hold_idx_q <= '0;
      end else begin
         hold_q     <= stall;
         hold_idx_q <= grant;
         if (take) ptr_q <= (grant == IW'(NUM_SRC - 1)) ? '0 : grant + 1'b1;
      end
   end

   // R5: when any queue holds data, the granted queue is one of them.
   a_r5_grant_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[grant]);

   // R6: without a transfer the pointer keeps its value.
   a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(ptr_q));

   // R6: after a transfer the pointer moves to the served source plus one.
   a_r6_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ptr_q == (($past(grant) == IW'(NUM_SRC - 1)) ? '0 : $past(grant) + 1'b1)));

   // R7: a stall keeps the grant on the same source in the next cycle.
   a_r7_grant_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(grant));

endmodule

// File: rtl/rr_queue_mux.sv
module rr_queue_mux #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          src_valid,
   output logic [NUM_SRC-1:0]          src_ready,
   input  logic [NUM_SRC*DATA_W-1:0]   src_data,
   output logic                        dst_valid,
   input  logic                        dst_ready,
   output logic [DATA_W-1:0]           dst_data
);
   import rqm_pkg::*;

   localparam int unsigned IW = idx_w(NUM_SRC);

   generate
      if (NUM_SRC < 2)  begin : g_bad_src   $error("rr_queue_mux: NUM_SRC must be at least 2");  end
      if (DEPTH < 1)    begin : g_bad_depth $error("rr_queue_mux: DEPTH must be at least 1");    end
      if (DATA_W < 1)   begin : g_bad_width $error("rr_queue_mux: DATA_W must be at least 1");   end
   endgenerate

   logic [NUM_SRC-1:0] avail;
   logic [DATA_W-1:0]  heads [NUM_SRC];
   logic [IW-1:0]      grant;
   logic               any, take, stall;

   assign dst_valid = any;
   assign take      = any & dst_ready;
   assign stall     = any & ~dst_ready;
   assign dst_data  = heads[grant];

   for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_q
      rqm_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_valid (src_valid[s]),
         .wr_ready (src_ready[s]),
         .wr_data  (src_data[s*DATA_W +: DATA_W]),
         .rd_pop   (take && (grant == IW'(s))),
         .rd_data  (heads[s]),
         .rd_avail (avail[s])
      );
   end

   rqm_rr_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (avail),
      .take  (take),
      .stall (stall),
      .grant (grant),
      .any   (any)
   );

   // R7: a stalled output word stays on the port in the next cycle.
   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

   // R1: the first cycle after reset shows empty queues.
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!dst_valid && (&src_ready)));

endmodule

// File: tb/sim_rr_queue_mux.sv
module sim_rr_queue_mux;
   localparam int NS = 4;
   localparam int DP = 4;
   localparam int DW = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NS-1:0]      src_valid = '0;
   logic [NS-1:0]      src_ready;
   logic [NS*DW-1:0]   src_data = '0;
   logic               dst_valid;
   logic               dst_ready = 1'b0;
   logic [DW-1:0]      dst_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Reference model state
   logic [DW-1:0] mq [NS][$];
   int            mptr = 0;
   bit            mhold = 1'b0;
   int            mhold_idx = 0;
   int            seq [NS];

   always #5 clk = ~clk;

   rr_queue_mux #(.NUM_SRC(NS), .DEPTH(DP), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data)
   );

   function automatic int model_grant();
      if (mhold) return mhold_idx;
      for (int k = 0; k < NS; k++) begin
         int p;
         p = (mptr + k) % NS;
         if (mq[p].size() > 0) return p;
      end
      return mptr;
   endfunction

   function automatic bit model_any();
      for (int s = 0; s < NS; s++) if (mq[s].size() > 0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: compare outputs with the model, drive inputs, advance the model.
   task automatic step(input logic [NS-1:0] v, input logic rdy, input string tag);
      logic [NS-1:0] eready;
      bit            ev;
      int            g;
      @(negedge clk);
      ev = model_any();
      g  = model_grant();
      for (int s = 0; s < NS; s++) eready[s] = (mq[s].size() < DP);
      chk({tag, " R4 dst_valid"}, 64'(dst_valid), 64'(ev));
      chk({tag, " R3,R8 src_ready"}, 64'(src_ready), 64'(eready));
      if (ev) chk({tag, " R2,R5,R6,R7 dst_data"}, 64'(dst_data), 64'(mq[g][0]));
      src_valid = v;
      dst_ready = rdy;
      for (int s = 0; s < NS; s++)
         src_data[s*DW +: DW] = {8'(s), 24'(seq[s])};
      // model update: pop, then push
      if (ev && rdy) begin
         void'(mq[g].pop_front());
         mptr = (g + 1) % NS;
      end
      mhold     = ev && !rdy;
      mhold_idx = g;
      for (int s = 0; s < NS; s++) begin
         if (v[s] && eready[s]) begin
            mq[s].push_back({8'(s), 24'(seq[s])});
            seq[s]++;
         end
      end
   endtask

   initial begin
      #(10 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < NS; s++) seq[s] = 0;
      // R1: outputs during reset
      repeat (3) @(negedge clk);
      chk("R1 reset dst_valid", 64'(dst_valid), 64'(0));
      chk("R1 reset src_ready", 64'(src_ready), 64'({NS{1'b1}}));
      rst_n = 1'b1;
      // R1: all sources write together; source 0 must come out first
      step('1, 1'b0, "R1 first");
      step('0, 1'b0, "R1 first");
      step('0, 1'b1, "R1 first");
      repeat (6) step('0, 1'b1, "R5 drain");
      // R3: back-pressure fills every queue, then release
      repeat (8) step('1, 1'b0, "R3 fill");
      repeat (3) step('1, 1'b1, "R3 pop-when-full");
      repeat (4) step('1, 1'b0, "R7 stall");
      repeat (20) step('0, 1'b1, "R3 release");
      // R5: sparse sources, empty queues skipped
      repeat (12) step(4'b1100, 1'b1, "R5 sparse");
      repeat (6) step('0, 1'b1, "R5 sparse");
      // R7: stall on source 2, then a higher-priority source arrives
      step(4'b0100, 1'b0, "R7 hold");
      step(4'b0001, 1'b0, "R7 hold");
      step('0, 1'b0, "R7 hold");
      repeat (4) step('0, 1'b1, "R7 hold");
      // R8: steady single-source stream with simultaneous push and pop
      repeat (10) step(4'b0010, 1'b1, "R8 stream");
      repeat (4) step('0, 1'b1, "R8 stream");
      // Random traffic with varying densities
      for (int ph = 0; ph < 8; ph++) begin
         for (int c = 0; c < 400; c++) begin
            logic [NS-1:0] v;
            for (int s = 0; s < NS; s++) v[s] = (($urandom % 8) < (ph % 4) * 2 + 1);
            step(v, (($urandom % 8) < (8 - ph)), "RND");
         end
      end
      repeat (40) step('0, 1'b1, "R2 final drain");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule